// File: doc/BRIEF.md
# Per-Page Delta Tracker

This block sits in front of a delta-transition predictor. Each incoming access is a line address, split into a page number and a 6-bit line offset within the page. A delta is computed against the last access to the same page, not against the last access overall. Because of this, several pages touched in an interleaved order still yield clean within-page deltas. When two successive deltas exist for a page, the block emits the pair (older delta, newer delta) as one transition. The predictor downstream consumes these pairs.

Storage is a set-associative table of 64 sets by 4 ways. The low 6 page bits select the set and the next 10 bits form the tag. Only these 16 page bits enter the block, so pages that differ only above them share an entry, and such false matches are accepted. Each entry holds:
- a valid bit
- the 10-bit tag
- the last line offset
- the last delta, a 7-bit two's-complement value
- one not-recently-used (NRU) bit

The pattern 7'b1000000 (-64) is never a real delta. It marks an entry that has no delta yet.

Top module: `page_delta_tracker`

## Requirements
- R1: After reset every entry is empty and the outputs are low. The first access to any page misses and produces no transition.
- R2: The set index is accPage[5:0] and the tag is accPage[15:6]. Pages that share a set but differ in tag occupy separate ways and do not disturb each other's state.
- R3: On a miss the chosen way is filled with the tag, the access offset and the no-delta marker -64 (7'b1000000), and no transition is produced. The next access to that page with a different offset also produces no transition, but it records its delta.
- R4: The current delta is the new offset minus the stored offset, as a 7-bit two's-complement value in -63..+63.
- R5: A hit with a nonzero delta whose stored delta is not -64 raises xferValid, with xferPrev equal to the stored delta and xferCur equal to the new delta. The entry then stores the new delta and the new offset.
- R6: A hit whose delta is zero (same line again) produces no transition and leaves the entry's offset and delta unchanged.
- R7: Accesses to different pages in an interleaved order each yield the transitions their own page sequence gives.
- R8: Each access sets the NRU bit of the way it touches. If that would set every bit in the set, all other bits of the set are cleared. On a miss the victim is the lowest-index way whose NRU bit is clear.
- R9: The outputs are registered. xferValid is high for exactly the cycle after the access that produced the transition. xferPrev and xferCur read zero whenever xferValid is low.
- R10: Accesses on consecutive cycles to the same page each see the update made by the access before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | An access is presented this cycle |
| accPage | input | 16 | Low page-number bits: set index [5:0], tag [15:6] |
| accOffset | input | 6 | Line offset of the access within its page |
| xferValid | output | 1 | A delta transition is presented |
| xferPrev | output | 7 | Older delta of the transition (two's complement) |
| xferCur | output | 7 | Newer delta of the transition (two's complement) |

## Verification
The bench goes after these corner cases:
- **Second touch of a page.** A design that skips the -64 marker would emit a bogus transition here.
- **Repeated line.** A design that writes on a zero delta would corrupt the next transition with a zero older delta.
- **Offset extremes 0 and 63.** A wrong subtraction width would wrap the ±63 deltas.
- **Interleaved pages in one set.** A design that keeps one global last address would produce mixed-page deltas.
- **Sets filled past their four ways.** A pseudo-random phase drives this. It exposes a wrong victim choice or a missing clear of the NRU bits, because a wrongly evicted page later misses where the reference model still hits.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

  // Control-to-datapath strobes for one access
  typedef struct packed {
    logic wrEn;   // write the target way this cycle
    logic alloc;  // the write is a fresh allocation
    logic emit;   // present a transition next cycle
  } pdt_strobe_t;

endpackage

// File: rtl/pdt_control.sv
module pdt_control
  import pdt_pkg::*;
#(
  parameter int SETS     = 64,
  parameter int WAYS     = 4,
  localparam int SET_BITS = $clog2(SETS),
  localparam int WAY_BITS = $clog2(WAYS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                accValid,
  input  logic [SET_BITS-1:0] setIdx,
  input  logic [WAYS-1:0]     hitVec,
  input  logic                deltaZero,
  input  logic                prevIsNone,
  output pdt_strobe_t         strobes,
  output logic [WAY_BITS-1:0] tgtWay
);

  logic [WAYS-1:0]     nruBits [SETS];
  logic [WAYS-1:0]     curRow;
  logic [WAYS-1:0]     nextRow;
  logic [WAY_BITS-1:0] hitWay;
  logic [WAY_BITS-1:0] victimWay;
  logic                anyHit;

  assign curRow = nruBits[setIdx];
  assign anyHit = |hitVec;

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hitVec[w]) hitWay = WAY_BITS'(w);
    end
  end

  // lowest-index way with a clear NRU bit
  always_comb begin
    victimWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!curRow[w]) victimWay = WAY_BITS'(w);
    end
  end

  assign tgtWay = anyHit ? hitWay : victimWay;

  always_comb begin
    strobes.wrEn  = accValid && !(anyHit && deltaZero);
    strobes.alloc = accValid && !anyHit;
    strobes.emit  = accValid && anyHit && !deltaZero && !prevIsNone;
  end

  always_comb begin
    nextRow = curRow | (WAYS'(1) << tgtWay);
    if (&nextRow) nextRow = WAYS'(1) << tgtWay;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) nruBits[s] <= '0;
    end else if (accValid) begin
      nruBits[setIdx] <= nextRow;
    end
  end

  // R8
  nru_never_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> (nruBits[$past(setIdx)] != {WAYS{1'b1}}));

  // R8
  nru_touched_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> nruBits[$past(setIdx)][$past(tgtWay)]);

  // R2
  single_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    accValid |-> $onehot0(hitVec));

endmodule

// File: rtl/pdt_datapath.sv
module pdt_datapath
  import pdt_pkg::*;
#(
  parameter int SETS     = 64,
  parameter int WAYS     = 4,
  parameter int TAG_W    = 10,
  parameter int OFFS_W   = 6,
  localparam int SET_BITS = $clog2(SETS),
  localparam int WAY_BITS = $clog2(WAYS),
  localparam int PAGE_W   = SET_BITS + TAG_W,
  localparam int DW       = OFFS_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                accValid,
  input  logic [PAGE_W-1:0]   accPage,
  input  logic [OFFS_W-1:0]   accOffset,
  input  pdt_strobe_t         strobes,
  input  logic [WAY_BITS-1:0] tgtWay,
  output logic [SET_BITS-1:0] setIdx,
  output logic [WAYS-1:0]     hitVec,
  output logic                deltaZero,
  output logic                prevIsNone,
  output logic                xferValid,
  output logic [DW-1:0]       xferPrev,
  output logic [DW-1:0]       xferCur
);

  localparam logic [DW-1:0] NONE_DELTA = {1'b1, {OFFS_W{1'b0}}};

  logic                validMem [SETS][WAYS];
  logic [TAG_W-1:0]    tagMem   [SETS][WAYS];
  logic [OFFS_W-1:0]   offMem   [SETS][WAYS];
  logic [DW-1:0]       deltaMem [SETS][WAYS];

  logic [TAG_W-1:0]    accTag;
  logic [OFFS_W-1:0]   hitOff;
  logic [DW-1:0]       hitDelta;
  logic [DW-1:0]       newDelta;

  assign setIdx = accPage[SET_BITS-1:0];
  assign accTag = accPage[SET_BITS +: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_match
    assign hitVec[w] = validMem[setIdx][w] && (tagMem[setIdx][w] == accTag);
  end

  always_comb begin
    hitOff   = '0;
    hitDelta = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hitVec[w]) begin
        hitOff   |= offMem[setIdx][w];
        hitDelta |= deltaMem[setIdx][w];
      end
    end
  end

  assign newDelta   = {1'b0, accOffset} - {1'b0, hitOff};
  assign deltaZero  = (newDelta == '0);
  assign prevIsNone = (hitDelta == NONE_DELTA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          validMem[s][w] <= 1'b0;
          tagMem[s][w]   <= '0;
          offMem[s][w]   <= '0;
          deltaMem[s][w] <= NONE_DELTA;
        end
      end
    end else if (strobes.wrEn) begin
      validMem[setIdx][tgtWay] <= 1'b1;
      tagMem[setIdx][tgtWay]   <= accTag;
      offMem[setIdx][tgtWay]   <= accOffset;
      deltaMem[setIdx][tgtWay] <= strobes.alloc ? NONE_DELTA : newDelta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xferValid <= 1'b0;
      xferPrev  <= '0;
      xferCur   <= '0;
    end else begin
      xferValid <= strobes.emit;
      xferPrev  <= strobes.emit ? hitDelta : '0;
      xferCur   <= strobes.emit ? newDelta : '0;
    end
  end

  // R3
  alloc_marks_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.alloc |=> (deltaMem[$past(setIdx)][$past(tgtWay)] == NONE_DELTA));

  // R5
  xfer_prev_real_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferValid |-> (xferPrev != NONE_DELTA));

  // R6
  xfer_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferValid |-> (xferCur != '0));

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !xferValid |-> (xferPrev == '0 && xferCur == '0));

  // R9
  no_access_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> !xferValid);

endmodule

// File: rtl/page_delta_tracker.sv
module page_delta_tracker
  import pdt_pkg::*;
#(
  parameter int SETS   = 64,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 10,
  parameter int OFFS_W = 6,
  localparam int SET_BITS = $clog2(SETS),
  localparam int WAY_BITS = $clog2(WAYS),
  localparam int PAGE_W   = SET_BITS + TAG_W,
  localparam int DW       = OFFS_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [PAGE_W-1:0] accPage,
  input  logic [OFFS_W-1:0] accOffset,
  output logic              xferValid,
  output logic [DW-1:0]     xferPrev,
  output logic [DW-1:0]     xferCur
);

  pdt_strobe_t         strobes;
  logic [WAY_BITS-1:0] tgtWay;
  logic [SET_BITS-1:0] setIdx;
  logic [WAYS-1:0]     hitVec;
  logic                deltaZero;
  logic                prevIsNone;

  pdt_control #(.SETS(SETS), .WAYS(WAYS)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .accValid   (accValid),
    .setIdx     (setIdx),
    .hitVec     (hitVec),
    .deltaZero  (deltaZero),
    .prevIsNone (prevIsNone),
    .strobes    (strobes),
    .tgtWay     (tgtWay)
  );

  pdt_datapath #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .OFFS_W(OFFS_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .accValid   (accValid),
    .accPage    (accPage),
    .accOffset  (accOffset),
    .strobes    (strobes),
    .tgtWay     (tgtWay),
    .setIdx     (setIdx),
    .hitVec     (hitVec),
    .deltaZero  (deltaZero),
    .prevIsNone (prevIsNone),
    .xferValid  (xferValid),
    .xferPrev   (xferPrev),
    .xferCur    (xferCur)
  );

endmodule

// File: tb/page_delta_tracker_bench.sv
module page_delta_tracker_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic [15:0] accPage = '0;
  logic [5:0]  accOffset = '0;
  logic        xferValid;
  logic [6:0]  xferPrev;
  logic [6:0]  xferCur;

  int checks = 0;
  int failures = 0;

  // behavioural reference: 64 sets x 4 ways, flattened
  int mValid [256];
  int mTag   [256];
  int mOff   [256];
  int mDelta [256];
  int mNru   [256];

  int    expV = 0, expP = 0, expC = 0;
  string expTag = "R1";
  int    lcg = 12345;

  always #2.5 clk = ~clk;

  page_delta_tracker u_page_delta_tracker (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accPage(accPage),
    .accOffset(accOffset), .xferValid(xferValid), .xferPrev(xferPrev), .xferCur(xferCur)
  );

  task automatic compareOut();
    int aP, aC;
    aP = int'($signed(xferPrev));
    aC = int'($signed(xferCur));
    checks++;
    if (int'(xferValid) != expV || aP != expP || aC != expC) begin
      failures++;
      $display("FAIL %s: got valid=%0d prev=%0d cur=%0d, expected valid=%0d prev=%0d cur=%0d",
               expTag, xferValid, aP, aC, expV, expP, expC);
    end
  endtask

  task automatic modelAccess(input int page, input int off);
    int s, tg, hw, vw, d, row;
    s = page % 64;
    tg = (page / 64) % 1024;
    hw = -1;
    expV = 0; expP = 0; expC = 0;
    for (int w = 0; w < 4; w++)
      if (mValid[s*4+w] != 0 && mTag[s*4+w] == tg) hw = w;
    if (hw >= 0) begin
      d = off - mOff[s*4+hw];
      if (d != 0) begin
        if (mDelta[s*4+hw] != -64) begin
          expV = 1; expP = mDelta[s*4+hw]; expC = d;
        end
        mDelta[s*4+hw] = d;
        mOff[s*4+hw] = off;
      end
      vw = hw;
    end else begin
      vw = -1;
      for (int w = 3; w >= 0; w--) if (mNru[s*4+w] == 0) vw = w;
      mValid[s*4+vw] = 1; mTag[s*4+vw] = tg; mOff[s*4+vw] = off; mDelta[s*4+vw] = -64;
    end
    mNru[s*4+vw] = 1;
    row = 0;
    for (int w = 0; w < 4; w++) row += mNru[s*4+w];
    if (row == 4) for (int w = 0; w < 4; w++) if (w != vw) mNru[s*4+w] = 0;
  endtask

  // compare last cycle's result, drive the next access, advance one clock
  task automatic step(input bit v, input int page, input int off, input string tag);
    compareOut();
    accValid = v;
    accPage = 16'(page);
    accOffset = 6'(off);
    if (v) modelAccess(page, off);
    else begin expV = 0; expP = 0; expC = 0; end
    expTag = tag;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got no finish, expected finish before timeout");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mValid[i] = 0; mTag[i] = 0; mOff[i] = 0; mDelta[i] = -64; mNru[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: outputs quiet after reset; first touch misses
    step(1'b0, 0, 0, "R1");
    step(1'b1, 16'h0012, 10, "R1");
    // R3: second touch records a delta only
    step(1'b1, 16'h0012, 13, "R3");
    // R5 / R4: first real transition (3, -6)
    step(1'b1, 16'h0012, 7, "R5");
    // R6: same line again, no transition, entry untouched
    step(1'b1, 16'h0012, 7, "R6");
    step(1'b1, 16'h0012, 9, "R6");
    step(1'b0, 0, 0, "R9");
    // R4: offset extremes
    step(1'b1, 16'h0033, 0, "R4");
    step(1'b1, 16'h0033, 63, "R4");
    step(1'b1, 16'h0033, 0, "R4");
    step(1'b1, 16'h0033, 63, "R4");
    // R2 / R7: two pages in set 0 with tags 1 and 2, interleaved
    step(1'b1, 16'h0040, 5, "R2");
    step(1'b1, 16'h0080, 40, "R2");
    step(1'b1, 16'h0040, 6, "R7");
    step(1'b1, 16'h0080, 38, "R7");
    step(1'b1, 16'h0040, 8, "R7");
    step(1'b1, 16'h0080, 35, "R7");
    step(1'b1, 16'h0040, 11, "R7");
    step(1'b1, 16'h0080, 31, "R7");
    // R10: back-to-back on one page
    step(1'b1, 16'h0055, 1, "R10");
    step(1'b1, 16'h0055, 2, "R10");
    step(1'b1, 16'h0055, 4, "R10");
    step(1'b1, 16'h0055, 7, "R10");
    step(1'b1, 16'h0055, 11, "R10");
    // R8: five pages into set 5, then revisit to expose the victim choice
    for (int t = 0; t < 5; t++) step(1'b1, (t + 1) * 64 + 5, 3, "R8");
    for (int t = 0; t < 5; t++) step(1'b1, (t + 1) * 64 + 5, 4, "R8");
    for (int t = 0; t < 5; t++) step(1'b1, (t + 1) * 64 + 5, 6, "R8");
    // R8 / R7: pseudo-random traffic over two sets and six tags
    for (int n = 0; n < 3000; n++) begin
      int pg, of;
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      pg = ((lcg >> 8) % 6) * 64 + 9 + ((lcg >> 4) % 2);
      of = (lcg >> 12) % 8;
      if ((lcg >> 20) % 7 == 0) step(1'b0, 0, 0, "R9");
      else step(1'b1, pg, of, "R8");
    end
    step(1'b0, 0, 0, "R9");
    compareOut();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule